// File: doc/BRIEF.md
# Bus Cycle Time-Over Watchdog

This block sits beside the external bus of a processor and ends any access that has stalled. It counts the clocks during which a bus cycle is in progress and the addressed device has not yet answered. When that count reaches a fixed limit (1024 clocks by default), the block supplies a ready of its own so the processor can finish the access. It also latches a time-over flag that acts as a maskable interrupt source.

The ready seen by the processor is the device ready combined with the forced one. Software clears the flag with a one-clock clear strobe. A mask input stops the flag from reaching the interrupt output, but the flag itself is left as it is. After a forced ready, the block stays quiet until the cycle-active signal goes low, so a stuck access yields exactly one forced ready and one flag event.

Top module: `bus_timeout_guard`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, `cpu_ready_o`, `tover_flag_o` and `tover_irq_o` are all 0.
- R2: A clock counts toward the limit when `cyc_active_i` is 1 and `dev_ready_i` is 0. When `LIMIT` such clocks in a row (default 1024) have been counted, `cpu_ready_o` is 1 in the next clock, even though `dev_ready_i` is 0.
- R3: A clock with `dev_ready_i` = 1, or with `cyc_active_i` = 0, restarts the count from zero. A device ready on the LIMIT-th clock therefore prevents a forced ready.
- R4: The forced ready lasts exactly one clock. After it, no further forced ready is produced until `cyc_active_i` has been 0 for at least one clock, however long the cycle stays active.
- R5: `cpu_ready_o` is 1 exactly when `dev_ready_i` is 1 or a forced ready is pending while `cyc_active_i` is 1. A forced ready that falls in a clock where `cyc_active_i` is 0 is dropped.
- R6: `tover_flag_o` becomes 1 in the same clock as the forced ready and stays 1 until it is cleared.
- R7: A clock with `tover_clr_i` = 1 clears `tover_flag_o` from the next clock on. If a time-over is declared on the same clock edge, the flag stays 1 (set wins).
- R8: `tover_irq_o` equals `tover_flag_o` while `irq_mask_i` is 0, and is 0 while `irq_mask_i` is 1. The mask does not change the flag.
- R9: A new time-over while the flag is already 1 leaves the flag at 1 and still produces its forced ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_active_i | input | 1 | A bus cycle is in progress |
| dev_ready_i | input | 1 | Ready from the addressed device |
| tover_clr_i | input | 1 | Software clear strobe for the flag |
| irq_mask_i | input | 1 | 1 blocks the interrupt output |
| cpu_ready_o | output | 1 | Combined ready to the processor |
| tover_flag_o | output | 1 | Sticky time-over flag |
| tover_irq_o | output | 1 | Masked time-over interrupt request |

## Verification
Two pairs of events can coincide. A software clear can land on the edge where a new time-over sets the flag. The device ready can arrive in the very clock where the forced ready is presented, or on the LIMIT-th counted clock. The bench provokes each case by timing the clear strobe, or the device ready, to those exact clocks. The reference model then decides the outcome clock by clock: set wins over clear, a late device ready still gives a single ready, and a device ready on the LIMIT-th clock cancels the time-over.

// File: rtl/tover_pkg.sv
package tover_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_HELD  = 2'd2
    } tover_phase_e;

endpackage

// File: rtl/tover_counter.sv
module tover_counter
    import tover_pkg::*;
#(
    parameter int LIMIT = 1024,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic act_i,
    input  logic rdy_i,
    output logic expire_o,
    output logic fire_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        tover_phase_e     phase;
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fire = 1'b0;
        if (!act_i) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
        end else begin
            case (s_q.phase)
                PH_HELD: begin
                    s_d.phase = PH_HELD;
                end
                default: begin
                    if (rdy_i) begin
                        s_d.phase = PH_COUNT;
                        s_d.cnt   = '0;
                    end else if (s_q.cnt == LAST) begin
                        s_d.phase = PH_HELD;
                        s_d.cnt   = s_q.cnt + 1'b1;
                        s_d.fire  = 1'b1;
                    end else begin
                        s_d.phase = PH_COUNT;
                        s_d.cnt   = s_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, fire: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign expire_o = s_d.fire;
    assign fire_o   = s_q.fire;

endmodule

// File: rtl/tover_flag.sv
module tover_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (set_i) begin
            f_d.flag = 1'b1;
        end else if (clr_i) begin
            f_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q <= '{flag: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign flag_o = f_q.flag;

endmodule

// File: rtl/bus_timeout_guard.sv
module bus_timeout_guard #(
    parameter int LIMIT = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cyc_active_i,
    input  logic dev_ready_i,
    input  logic tover_clr_i,
    input  logic irq_mask_i,
    output logic cpu_ready_o,
    output logic tover_flag_o,
    output logic tover_irq_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic expire_w;
    logic fire_w;
    logic forced_w;

    tover_counter #(
        .LIMIT (LIMIT),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .act_i    (cyc_active_i),
        .rdy_i    (dev_ready_i),
        .expire_o (expire_w),
        .fire_o   (fire_w)
    );

    tover_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (expire_w),
        .clr_i  (tover_clr_i),
        .flag_o (tover_flag_o)
    );

    assign forced_w    = fire_w & cyc_active_i;
    assign cpu_ready_o = dev_ready_i | forced_w;
    assign tover_irq_o = tover_flag_o & ~irq_mask_i;

endmodule

// File: rtl/tover_checks.sv
module tover_checks (
    input logic clk_i,
    input logic rst_ni,
    input logic cyc_active_i,
    input logic dev_ready_i,
    input logic tover_clr_i,
    input logic irq_mask_i,
    input logic cpu_ready_o,
    input logic tover_flag_o,
    input logic tover_irq_o,
    input logic forced_w
);

    // R4: a forced ready never lasts two clocks
    a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        forced_w |=> !forced_w);

    // R3: no forced ready outside a bus cycle
    a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_active_i |-> !forced_w);

    // R5: without either ready source the processor sees no ready
    a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dev_ready_i && !forced_w) |-> !cpu_ready_o);

    // R6: the flag is up whenever a forced ready is presented
    a_r6_flag_with_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
        forced_w |-> tover_flag_o);

    // R7: without a clear strobe the flag never falls
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tover_flag_o && !tover_clr_i) |=> tover_flag_o);

    // R8: the mask blocks the request
    a_r8_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_mask_i |-> !tover_irq_o);

endmodule

bind bus_timeout_guard tover_checks u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_active_i (cyc_active_i),
    .dev_ready_i  (dev_ready_i),
    .tover_clr_i  (tover_clr_i),
    .irq_mask_i   (irq_mask_i),
    .cpu_ready_o  (cpu_ready_o),
    .tover_flag_o (tover_flag_o),
    .tover_irq_o  (tover_irq_o),
    .forced_w     (forced_w)
);

// File: tb/sim_bus_timeout_guard.sv
module sim_bus_timeout_guard;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act = 1'b0;
    logic rdy = 1'b0;
    logic clr = 1'b0;
    logic mask = 1'b0;
    logic cpu_ready, flag, irq;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference state
    int m_run  = 0;
    bit m_held = 0;
    bit m_fire = 0;
    bit m_flag = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_timeout_guard #(.LIMIT(LIMIT)) u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cyc_active_i (act),
        .dev_ready_i  (rdy),
        .tover_clr_i  (clr),
        .irq_mask_i   (mask),
        .cpu_ready_o  (cpu_ready),
        .tover_flag_o (flag),
        .tover_irq_o  (irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_held = 0; m_fire = 0; m_flag = 0;
        end else begin
            bit hit;
            hit = 0;
            if (!act) begin
                m_run = 0; m_held = 0;
            end else if (!m_held) begin
                if (rdy) m_run = 0;
                else begin
                    m_run = m_run + 1;
                    if (m_run == LIMIT) begin hit = 1; m_held = 1; end
                end
            end
            m_fire = hit;
            if (hit) m_flag = 1;
            else if (clr) m_flag = 0;
        end
    end

    task automatic chk(string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            chk("ready", cpu_ready, rdy | (m_fire & act));
            chk("flag", flag, m_flag);
            chk("irq", irq, m_flag & ~mask);
        end
    end

    task automatic step(logic a, logic r, logic c, logic m, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            act = a; rdy = r; clr = c; mask = m;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        tag = "R1";
        step(0, 0, 0, 0, 3);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 2);

        // R2 / R4 / R6: stalled cycle held long past the limit
        tag = "R2_R4_R6";
        step(1, 0, 0, 0, 2 * LIMIT + 50);
        step(0, 0, 0, 0, 2);

        // R7 plain clear
        tag = "R7";
        step(0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 2);

        // R3 device ready restarts the count
        tag = "R3";
        step(1, 0, 0, 0, LIMIT - 1);
        step(1, 1, 0, 0, 1);
        step(1, 0, 0, 0, LIMIT - 1);
        step(0, 0, 0, 0, 1);
        step(1, 0, 0, 0, LIMIT - 1);
        step(1, 1, 0, 0, 1);      // ready on the LIMIT-th clock cancels it
        step(0, 0, 0, 0, 2);

        // R5: device ready in the forced-ready clock, then a drop in that clock
        tag = "R5";
        step(1, 0, 0, 0, LIMIT);
        step(1, 1, 0, 0, 1);
        step(0, 0, 0, 0, 2);
        step(1, 0, 0, 0, LIMIT);
        step(0, 0, 0, 0, 3);

        // R9: another time-over while the flag is still up
        tag = "R9";
        step(1, 0, 0, 0, LIMIT + 3);
        step(0, 0, 0, 0, 2);

        // R7 collision: clear on the edge that declares a time-over
        tag = "R7_collide";
        step(1, 0, 0, 0, LIMIT - 1);
        step(1, 0, 1, 0, 1);
        step(1, 0, 0, 0, 3);
        step(0, 0, 0, 0, 2);

        // R8 mask
        tag = "R8";
        step(0, 0, 0, 1, 3);
        step(0, 0, 0, 0, 2);
        step(0, 0, 1, 1, 1);
        step(1, 0, 0, 1, LIMIT + 2);
        step(0, 0, 0, 1, 2);
        step(0, 0, 0, 0, 2);

        @(negedge clk);
        #(CLK_PERIOD / 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule